// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a data cache with a configurable number of ways, sets and block size. It sits between a single requester and a slower memory level. The requester presents a 32-bit byte address, a read/write flag and one data word. Hits are answered from local storage in one cycle. A read miss brings the whole block in from below and installs it in the set. A write miss is passed down as a single-word write and does not allocate a line.

Each way of each set keeps a tag, a valid bit and a dirty bit. Fills go into the lowest-numbered empty way of the set. When the set is full, a wrapping counter kept for each set names the way to replace. That counter moves on only when a line is actually evicted. A dirty victim is written down as a whole block before its replacement is fetched.

Top module: `cache_ctrl`

## Requirements
- R1: A read whose tag matches a valid way of the indexed set raises `resp_valid` in the cycle after acceptance, with no lower-level request. The address splits into byte offset `[3:0]`, set index `[7:4]` and tag `[31:8]`, and the returned word is the one selected by address bits `[3:2]`.
- R2: A read miss issues a block read (`mem_req_write`=0, `mem_req_line`=1) at the block-aligned address. The request is held until `mem_req_ready` is seen. When `mem_rsp_valid` arrives, the block is installed and the addressed word is returned.
- R3: If the set has invalid ways, the fill goes into the lowest-numbered invalid way, and the set's replacement counter does not change.
- R4: If all ways are valid, the victim is the way named by the set's counter. The counter then advances by one and wraps from WAYS-1 to 0.
- R5: A dirty victim is first sent down as a whole-block write (`mem_req_write`=1, `mem_req_line`=1) at the victim's own address, and the fill read is issued only after that. A clean victim causes no write.
- R6: A write hit updates only the cached word and marks the line dirty. It produces no lower-level request and answers in the cycle after acceptance.
- R7: A write miss sends exactly one single-word write (`mem_req_write`=1, `mem_req_line`=0) carrying the requester's address and data, and leaves the cache contents unchanged. A later read of that address therefore misses.
- R8: `req_ready` is low from the acceptance of a miss until its response, so only one access is ever outstanding.
- R9: Reset clears every valid bit, dirty bit and replacement counter. After reset `req_ready` is high and `resp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Requester presents an access |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data (zero for writes) |
| mem_req_valid | output | 1 | Lower-level request valid |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = block read |
| mem_req_line | output | 1 | 1 = whole block, 0 = single word |
| mem_req_addr | output | 32 | Request address (block-aligned for block transfers) |
| mem_req_wdata | output | 32 | Word for a forwarded write |
| mem_req_wline | output | 128 | Block for a write-back |
| mem_rsp_valid | input | 1 | Fill data valid |
| mem_rsp_line | input | 128 | Fill block |

## Verification
The bench builds the controller with its defaults: four ways, sixteen sets and sixteen-byte blocks. With four ways, one set can be filled through every empty way. The bench then drives the replacement counter through a full wrap, with a dirty victim sitting exactly at counter zero. Sixteen-byte blocks hold four words, so a word written on a hit can be followed through a write-back and a refill to a different word offset. The lower-level model stalls every request for two cycles, which exercises the holding of requests and the busy period on `req_ready`.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVICT,
        S_FETCH,
        S_AWAIT,
        S_FORWARD
    } ctl_state_e;

    // Index width that never collapses to zero bits.
    function automatic int unsigned safe_log2(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cache_tag_array.sv
module cache_tag_array #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 16,
    parameter int unsigned TAG_W = 24,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [IDX_W-1:0]                lk_idx,
    input  logic [TAG_W-1:0]                lk_tag,
    output logic                            lk_hit,
    output logic [WAY_W-1:0]                lk_way,
    output logic [WAYS-1:0]                 set_valid,
    output logic [WAYS-1:0]                 set_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]      set_tags,
    input  logic                            dirty_en,
    input  logic [IDX_W-1:0]                dirty_idx,
    input  logic [WAY_W-1:0]                dirty_way,
    input  logic                            inst_en,
    input  logic [IDX_W-1:0]                inst_idx,
    input  logic [WAY_W-1:0]                inst_way,
    input  logic [TAG_W-1:0]                inst_tag
);
    logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
    logic [WAYS-1:0]            valid_q [SETS];
    logic [WAYS-1:0]            dirty_q [SETS];
    logic [WAYS-1:0]            match;

    assign set_valid = valid_q[lk_idx];
    assign set_dirty = dirty_q[lk_idx];
    assign set_tags  = tag_q[lk_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    always_comb begin
        lk_hit = |match;
        lk_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) lk_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (dirty_en) dirty_q[dirty_idx][dirty_way] <= 1'b1;
            if (inst_en) begin
                tag_q[inst_idx][inst_way]   <= inst_tag;
                valid_q[inst_idx][inst_way] <= 1'b1;
                dirty_q[inst_idx][inst_way] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned SETS  = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAYS-1:0]   set_valid,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [WAY_W-1:0]  vic_way,
    output logic              vic_evict,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  adv_idx
);
    logic [WAY_W-1:0] rr_q [SETS];

    // Lowest empty way wins; otherwise the set's rotating pointer.
    always_comb begin
        vic_way   = rr_q[sel_idx];
        vic_evict = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) begin
                vic_way   = WAY_W'(w);
                vic_evict = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (adv_en) begin
            if (rr_q[adv_idx] == WAY_W'(WAYS - 1)) rr_q[adv_idx] <= '0;
            else                                   rr_q[adv_idx] <= rr_q[adv_idx] + 1'b1;
        end
    end
endmodule

// File: rtl/cache_line_ram.sv
module cache_line_ram #(
    parameter int unsigned WAYS   = 4,
    parameter int unsigned SETS   = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LINE_W = 128,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned WAY_W  = 2,
    parameter int unsigned WOFF_W = 2
) (
    input  logic              clk,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_word_en,
    input  logic [WAY_W-1:0]  wr_word_way,
    input  logic [IDX_W-1:0]  wr_word_idx,
    input  logic [WOFF_W-1:0] wr_word_off,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              wr_line_en,
    input  logic [WAY_W-1:0]  wr_line_way,
    input  logic [IDX_W-1:0]  wr_line_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] mem_q [SETS][WAYS];

    assign rd_line = mem_q[rd_idx][rd_way];

    always_ff @(posedge clk) begin
        if (wr_line_en) begin
            mem_q[wr_line_idx][wr_line_way] <= wr_line;
        end else if (wr_word_en) begin
            mem_q[wr_word_idx][wr_word_way][wr_word_off*DATA_W +: DATA_W] <= wr_word;
        end
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned WAYS        = 4,
    parameter int unsigned SETS        = 16,
    parameter int unsigned BLOCK_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       resp_valid,
    output logic [DATA_W-1:0]          resp_rdata,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_write,
    output logic                       mem_req_line,
    output logic [ADDR_W-1:0]          mem_req_addr,
    output logic [DATA_W-1:0]          mem_req_wdata,
    output logic [BLOCK_BYTES*8-1:0]   mem_req_wline,
    input  logic                       mem_rsp_valid,
    input  logic [BLOCK_BYTES*8-1:0]   mem_rsp_line
);
    localparam int unsigned LINE_W = BLOCK_BYTES * 8;
    localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES);
    localparam int unsigned BYTE_W = $clog2(DATA_W / 8);
    localparam int unsigned IDX_W  = safe_log2(SETS);
    localparam int unsigned WAY_W  = safe_log2(WAYS);
    localparam int unsigned WORDS  = BLOCK_BYTES / (DATA_W / 8);
    localparam int unsigned WOFF_W = safe_log2(WORDS);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;

    ctl_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_wdata_q;
    logic [WAY_W-1:0]  vic_way_q;
    logic              vic_evict_q;
    logic [TAG_W-1:0]  vic_tag_q;
    logic              resp_valid_q;
    logic [DATA_W-1:0] resp_rdata_q;

    logic [IDX_W-1:0]  r_idx, p_idx;
    logic [TAG_W-1:0]  r_tag, p_tag;
    logic [WOFF_W-1:0] r_woff, p_woff;

    logic                       lk_hit;
    logic [WAY_W-1:0]           lk_way;
    logic [WAYS-1:0]            set_valid, set_dirty;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic [WAY_W-1:0]           vic_way;
    logic                       vic_evict;
    logic [WAY_W-1:0]           rd_way;
    logic [IDX_W-1:0]           rd_idx;
    logic [LINE_W-1:0]          rd_line;
    logic [DATA_W-1:0]          hit_word, fill_word, resp_word;
    logic                       wr_word_en, fill_en, resp_set, latch_miss;

    assign r_idx  = req_addr[OFF_W +: IDX_W];
    assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign r_woff = req_addr[BYTE_W +: WOFF_W];
    assign p_idx  = pend_addr_q[OFF_W +: IDX_W];
    assign p_tag  = pend_addr_q[ADDR_W-1 -: TAG_W];
    assign p_woff = pend_addr_q[BYTE_W +: WOFF_W];

    assign req_ready  = (state_q == S_IDLE);
    assign resp_valid = resp_valid_q;
    assign resp_rdata = resp_rdata_q;

    assign rd_way    = (state_q == S_IDLE) ? lk_way : vic_way_q;
    assign rd_idx    = (state_q == S_IDLE) ? r_idx  : p_idx;
    assign hit_word  = rd_line[r_woff*DATA_W +: DATA_W];
    assign fill_word = mem_rsp_line[p_woff*DATA_W +: DATA_W];

    cache_tag_array #(
        .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (r_idx),
        .lk_tag    (r_tag),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .set_valid (set_valid),
        .set_dirty (set_dirty),
        .set_tags  (set_tags),
        .dirty_en  (wr_word_en),
        .dirty_idx (r_idx),
        .dirty_way (lk_way),
        .inst_en   (fill_en),
        .inst_idx  (p_idx),
        .inst_way  (vic_way_q),
        .inst_tag  (p_tag)
    );

    cache_victim_sel #(
        .WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_victim (
        .clk       (clk),
        .rst       (rst),
        .set_valid (set_valid),
        .sel_idx   (r_idx),
        .vic_way   (vic_way),
        .vic_evict (vic_evict),
        .adv_en    (fill_en && vic_evict_q),
        .adv_idx   (p_idx)
    );

    cache_line_ram #(
        .WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W), .LINE_W(LINE_W),
        .IDX_W(IDX_W), .WAY_W(WAY_W), .WOFF_W(WOFF_W)
    ) u_data (
        .clk         (clk),
        .rd_way      (rd_way),
        .rd_idx      (rd_idx),
        .rd_line     (rd_line),
        .wr_word_en  (wr_word_en),
        .wr_word_way (lk_way),
        .wr_word_idx (r_idx),
        .wr_word_off (r_woff),
        .wr_word     (req_wdata),
        .wr_line_en  (fill_en),
        .wr_line_way (vic_way_q),
        .wr_line_idx (p_idx),
        .wr_line     (mem_rsp_line)
    );

    always_comb begin
        state_d       = state_q;
        wr_word_en    = 1'b0;
        fill_en       = 1'b0;
        resp_set      = 1'b0;
        resp_word     = '0;
        latch_miss    = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_line  = 1'b0;
        mem_req_addr  = {p_tag, p_idx, OFF_W'(0)};
        mem_req_wdata = pend_wdata_q;
        mem_req_wline = rd_line;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (lk_hit) begin
                        resp_set = 1'b1;
                        if (req_write) wr_word_en = 1'b1;
                        else           resp_word  = hit_word;
                    end else begin
                        latch_miss = 1'b1;
                        if (req_write)                           state_d = S_FORWARD;
                        else if (vic_evict && set_dirty[vic_way]) state_d = S_EVICT;
                        else                                     state_d = S_FETCH;
                    end
                end
            end
            S_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_line  = 1'b1;
                mem_req_addr  = {vic_tag_q, p_idx, OFF_W'(0)};
                if (mem_req_ready) state_d = S_FETCH;
            end
            S_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_line  = 1'b1;
                if (mem_req_ready) state_d = S_AWAIT;
            end
            S_AWAIT: begin
                if (mem_rsp_valid) begin
                    fill_en   = 1'b1;
                    resp_set  = 1'b1;
                    resp_word = fill_word;
                    state_d   = S_IDLE;
                end
            end
            S_FORWARD: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = pend_addr_q;
                if (mem_req_ready) begin
                    resp_set = 1'b1;
                    state_d  = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            resp_valid_q <= 1'b0;
            resp_rdata_q <= '0;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            vic_way_q    <= '0;
            vic_evict_q  <= 1'b0;
            vic_tag_q    <= '0;
        end else begin
            state_q      <= state_d;
            resp_valid_q <= resp_set;
            if (resp_set) resp_rdata_q <= resp_word;
            if (latch_miss) begin
                pend_addr_q  <= req_addr;
                pend_wdata_q <= req_wdata;
                vic_way_q    <= vic_way;
                vic_evict_q  <= vic_evict;
                vic_tag_q    <= set_tags[vic_way];
            end
        end
    end
endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              lookup_hit,
    input logic              resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic              mem_req_line,
    input logic [ADDR_W-1:0] mem_req_addr
);
    // R1: a hit is answered on the following cycle
    p_hit_answer_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && lookup_hit |=> resp_valid);

    // R2: a pending lower-level request holds until accepted
    p_hold_request_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R5: an accepted block write-back is followed at once by the block fetch
    p_evict_then_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready && mem_req_write && mem_req_line
        |=> mem_req_valid && !mem_req_write && mem_req_line);

    // R6: a write hit produces no lower-level traffic
    p_write_hit_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && lookup_hit && req_write |=> !mem_req_valid);

    // R7: single-word transfers are always writes
    p_word_is_write_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_line |-> mem_req_write);

    // R8: requester is stalled while the lower level is in use
    p_busy_no_accept_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    // R9: the first cycle after reset is idle
    p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> req_ready && !resp_valid && !mem_req_valid);
endmodule

bind cache_ctrl cache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .lookup_hit    (lk_hit),
    .resp_valid    (resp_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_line  (mem_req_line),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_cache_ctrl.sv
module test_cache_ctrl;
    localparam logic [1:0] K_HIT = 2'd0, K_FILL = 2'd1, K_DIRTY = 2'd2, K_FWD = 2'd3;

    typedef struct packed {
        logic        wr;
        logic [23:0] tag;
        logic [1:0]  word;
        logic [31:0] wdata;
        logic [1:0]  kind;
    } vec_t;

    // All in set 3; four ways, counter starts at 0.
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h11, 2'd0, 32'h0,         K_FILL },  // R3 empty -> way0
        '{1'b0, 24'h11, 2'd1, 32'h0,         K_HIT  },  // R1
        '{1'b1, 24'h11, 2'd2, 32'hD1D1_0001, K_HIT  },  // R6 dirty way0
        '{1'b1, 24'h99, 2'd0, 32'hF0F0_0002, K_FWD  },  // R7 no allocate
        '{1'b0, 24'h99, 2'd0, 32'h0,         K_FILL },  // R7 still a miss -> way1
        '{1'b0, 24'h22, 2'd0, 32'h0,         K_FILL },  // R3 way2
        '{1'b0, 24'h33, 2'd3, 32'h0,         K_FILL },  // R3 way3, counter still 0
        '{1'b0, 24'h44, 2'd0, 32'h0,         K_DIRTY},  // R5 victim way0 dirty
        '{1'b0, 24'h11, 2'd2, 32'h0,         K_FILL },  // R4 victim way1, data from write-back
        '{1'b0, 24'h22, 2'd1, 32'h0,         K_HIT  },  // R4 way2 kept
        '{1'b0, 24'h55, 2'd0, 32'h0,         K_FILL },  // R4 victim way2
        '{1'b0, 24'h22, 2'd0, 32'h0,         K_FILL },  // R4 victim way3, counter wraps
        '{1'b0, 24'h66, 2'd0, 32'h0,         K_FILL },  // R4 victim way0
        '{1'b0, 24'h11, 2'd2, 32'h0,         K_HIT  },  // R1
        '{1'b0, 24'h33, 2'd0, 32'h0,         K_FILL },  // R4 victim way1
        '{1'b0, 24'h55, 2'd3, 32'h0,         K_HIT  },  // R4
        '{1'b0, 24'h22, 2'd2, 32'h0,         K_HIT  },  // R4
        '{1'b0, 24'h66, 2'd1, 32'h0,         K_HIT  }   // R4
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_ready, req_write;
    logic [31:0]  req_addr, req_wdata;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req_valid, mem_req_ready, mem_req_write, mem_req_line;
    logic [31:0]  mem_req_addr, mem_req_wdata;
    logic [127:0] mem_req_wline;
    logic         mem_rsp_valid;
    logic [127:0] mem_rsp_line;

    int checks = 0, errors = 0;
    int n_lwr, n_lrd, n_wwr, first_op;
    logic [31:0] memw   [logic [31:0]];
    logic [31:0] shadow [logic [31:0]];

    always #10 clk = ~clk;

    cache_ctrl i_cache_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_line(mem_req_line),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_wline(mem_req_wline),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h3C00_0000;
    endfunction

    function automatic logic [31:0] mk(input logic [23:0] t, input logic [3:0] s, input logic [1:0] w);
        return {t, s, w, 2'b00};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return memw.exists(a) ? memw[a] : pat(a);
    endfunction

    function automatic logic [31:0] arch_word(input logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : pat(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Lower-level model: two-cycle stall on every request, fill data two cycles after acceptance.
    initial begin
        int stall = 0, rsp_cnt = 0;
        logic [31:0] rsp_addr = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_line = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (rsp_cnt > 0) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    for (int k = 0; k < 4; k++) mem_rsp_line[k*32 +: 32] = mem_word(rsp_addr + 32'(4*k));
                end
            end else if (mem_req_valid === 1'b1) begin
                stall++;
                if (stall >= 2) begin
                    stall = 0;
                    mem_req_ready = 1'b1;
                    if (mem_req_write && mem_req_line) begin
                        for (int k = 0; k < 4; k++) memw[mem_req_addr + 32'(4*k)] = mem_req_wline[k*32 +: 32];
                        n_lwr++;
                        if (first_op == 0) first_op = 1;
                    end else if (mem_req_write) begin
                        memw[mem_req_addr] = mem_req_wdata;
                        n_wwr++;
                    end else begin
                        n_lrd++;
                        rsp_addr = mem_req_addr;
                        rsp_cnt  = 2;
                        if (first_op == 0) first_op = 2;
                    end
                end
            end
        end
    end

    // Starts and ends at a falling edge.
    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output int lat, output logic [31:0] rd, output bit busy_ok);
        n_lwr = 0; n_lrd = 0; n_wwr = 0; first_op = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ok = 1'b1;
        while (!resp_valid && lat < 100) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = resp_rdata;
        if (wr) shadow[a] = d;
    endtask

    task automatic run_one(input logic wr, input logic [31:0] a, input logic [31:0] d, input logic [1:0] kind);
        int lat; logic [31:0] rd; bit busy_ok;
        access(wr, a, d, lat, rd, busy_ok);
        case (kind)
            K_HIT: begin
                check(lat == 1 && n_lwr + n_lrd + n_wwr == 0, wr ? "R6" : "R1",
                      "hit latency/traffic", 32'(lat), 32'd1);
            end
            K_FILL: begin
                check(n_lrd == 1 && n_lwr == 0 && n_wwr == 0, "R2", "clean fill traffic",
                      32'(n_lrd*100 + n_lwr*10 + n_wwr), 32'd100);
                check(busy_ok, "R8", "ready low during miss", 32'(busy_ok), 32'd1);
            end
            K_DIRTY: begin
                check(n_lwr == 1 && n_lrd == 1 && first_op == 1, "R5", "write-back before fill",
                      32'(n_lrd*100 + n_lwr*10 + first_op), 32'd111);
                check(busy_ok, "R8", "ready low during miss", 32'(busy_ok), 32'd1);
            end
            default: begin
                check(n_wwr == 1 && n_lrd == 0 && n_lwr == 0 && memw[a] == d, "R7",
                      "forwarded word write", memw.exists(a) ? memw[a] : 32'hX, d);
            end
        endcase
        if (!wr) check(rd == arch_word(a), (kind == K_HIT) ? "R1" : "R2", "read data", rd, arch_word(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        n_lwr = 0; n_lrd = 0; n_wwr = 0; first_op = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req_valid, "R9", "idle after reset",
              {29'd0, req_ready, resp_valid, mem_req_valid}, 32'd4);

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i].wr, mk(VECS[i].tag, 4'd3, VECS[i].word), VECS[i].wdata, VECS[i].kind);
        end

        // R9: reset mid-run clears lines and the counter of set 3 (which stands at 2 here).
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req_valid, "R9", "idle after second reset",
              {29'd0, req_ready, resp_valid, mem_req_valid}, 32'd4);
        run_one(1'b0, mk(24'h66, 4'd3, 2'd0), 32'h0, K_FILL);  // R9 valid cleared -> way0
        run_one(1'b0, mk(24'h77, 4'd3, 2'd0), 32'h0, K_FILL);  // R3 way1
        run_one(1'b0, mk(24'h88, 4'd3, 2'd0), 32'h0, K_FILL);  // R3 way2
        run_one(1'b0, mk(24'hAA, 4'd3, 2'd0), 32'h0, K_FILL);  // R3 way3
        run_one(1'b0, mk(24'hBB, 4'd3, 2'd0), 32'h0, K_FILL);  // R9 counter 0 -> evicts way0
        run_one(1'b0, mk(24'h88, 4'd3, 2'd1), 32'h0, K_HIT);   // R4 way2 untouched
        run_one(1'b0, mk(24'h66, 4'd3, 2'd0), 32'h0, K_FILL);  // R9 line 0x66 was the victim

        // R1: a different set is independent of set 3.
        run_one(1'b0, mk(24'h11, 4'd9, 2'd3), 32'h0, K_FILL);
        run_one(1'b0, mk(24'h11, 4'd9, 2'd0), 32'h0, K_HIT);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule